// File: doc/BRIEF.md
# SD Data FIFO Packing Engine

This block sits between a processor-visible data port and the byte-wide data path of an SD card. A transfer is armed by writing a block count. The block multiplies it by the configured block size in bytes and uses the product as the remaining byte count. In the read direction, bytes arriving from the card are assembled into 32-bit words and queued in a 16-word FIFO. Software drains that FIFO through the host read port. In the write direction, words that software queued are taken from the FIFO and sent to the card one byte per clock.

The engine is a four-state machine:
- `ENG_IDLE` waits for a nonzero remaining count. It moves to `ENG_RD_GATHER` when the read direction is selected, or to `ENG_WR_FETCH` when the write direction is selected.
- `ENG_RD_GATHER` accepts one card byte per cycle. It returns to `ENG_IDLE` on the last byte.
- `ENG_WR_FETCH` pops one word and moves to `ENG_WR_SEND`.
- `ENG_WR_SEND` emits the bytes of that word. When the word is used up it goes back to `ENG_WR_FETCH`. When the count reaches zero it goes to `ENG_IDLE`.

Any block-count load sends the machine to `ENG_IDLE` from every state.

Three sticky status flags report activity. A debug output shows the FIFO fill level. A 4-bit mode field switches to data mode when a transfer finishes.

Top module: `sd_fifo_pack_engine`

## Requirements
- R1: The FIFO stores up to 16 words of 32 bits. `dbg_level` shows the current fill level (0 to 16) and changes by at most one per cycle.
- R2: A host push while the FIFO holds 16 words is dropped. `host_rd_data` reads 0 whenever the FIFO is empty, and a pop on an empty FIFO leaves the level at 0.
- R3: A `blk_cnt_wr` pulse loads the remaining byte count with `blk_cnt * blk_size`. The same pulse discards any partly assembled word and returns the engine to `ENG_IDLE`.
- R4: In the read direction a byte is taken only in a cycle where `card_rdy` is 1, at most one byte per cycle. Byte i of a word lands in bits 8i+7:8i, so the first byte goes in bits 7:0. A word is pushed once its fourth byte is taken.
- R5: While the FIFO holds 16 words, no card byte is taken (`card_rx_take` stays 0).
- R6: If the count runs out part-way through a word in the read direction, the partial word is pushed with its unused upper bytes set to zero.
- R7: In the write direction the engine pops a word and sends it over four cycles, least significant byte first, one byte per cycle on `card_tx_byte` with `card_tx_valid`. It needs no ready signal from the card. It waits while the FIFO is empty, and it sends no more bytes once the count is zero.
- R8: Each word the engine pushes or pops, and each byte it sends, sets `status[0]`. While `cfg_data_irq_en` is 1, the same events also set `status[8]`.
- R9: In the write direction, with `cfg_block_irq_en` at 1, `status[10]` is set on the byte after which the remaining count is a whole multiple of the nonzero block size. It is never set in the read direction.
- R10: `dbg_fsm` resets to 0x0. It becomes 0x1 in the cycle after the remaining count reaches zero, and it then stays at 0x1.
- R11: A host push or pop takes priority over the engine. While `host_wr_en` is 1 no card byte is taken, and while `host_rd_en` is 1 the engine does not pop.
- R12: A cycle with `stat_clr_en` at 1 clears every status bit whose bit in `stat_clr_mask` is 1, and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host pushes `host_wr_data` into the FIFO |
| host_wr_data | input | 32 | Word pushed by the host |
| host_rd_en | input | 1 | Host pops the FIFO head |
| host_rd_data | output | 32 | Current FIFO head, 0 when empty |
| xfer_read | input | 1 | Card-to-FIFO direction selected |
| xfer_write | input | 1 | FIFO-to-card direction selected |
| cfg_data_irq_en | input | 1 | Mirror data events into status bit 8 |
| cfg_block_irq_en | input | 1 | Enable the block-boundary flag, status bit 10 |
| blk_size | input | 10 | Block size in bytes |
| blk_cnt_wr | input | 1 | Load strobe for the block count |
| blk_cnt | input | 9 | Number of blocks |
| stat_clr_en | input | 1 | Apply the status clear mask |
| stat_clr_mask | input | 11 | Write-one-to-clear mask |
| status | output | 11 | Sticky flags at bits 0, 8 and 10 |
| card_rdy | input | 1 | Card has a read byte available |
| card_rx_byte | input | 8 | Byte from the card |
| card_rx_take | output | 1 | Byte consumed in this cycle |
| card_tx_valid | output | 1 | Byte sent to the card in this cycle |
| card_tx_byte | output | 8 | Byte to the card |
| dbg_fsm | output | 4 | Transfer mode field (0x0 at reset, 0x1 for data mode) |
| dbg_level | output | 5 | FIFO fill level |

## Verification
`card_rx_take` and `card_tx_valid` are combinational in the current cycle.

Several results land one clock edge later:
- the level change after a push or pop;
- a packed word after its fourth or final byte;
- each status flag after the triggering byte;
- the mode field after the final byte.

A transfer finishes roughly one cycle per byte plus one cycle per fetched word after the load. The bench drives inputs and samples outputs at the falling edge. Flag timing is checked cycle by cycle against the count of bytes already seen on the card port. Bulk results are read only after a wait that exceeds the transfer length by a margin.

// File: rtl/sd_pack_pkg.sv
package sd_pack_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE      = 2'd0,
        ENG_RD_GATHER = 2'd1,
        ENG_WR_FETCH  = 2'd2,
        ENG_WR_SEND   = 2'd3
    } eng_state_t;

    localparam int STAT_W        = 11;
    localparam int STAT_DATA     = 0;
    localparam int STAT_DATA_IRQ = 8;
    localparam int STAT_BLOCK    = 10;

    localparam logic [3:0] MODE_IDENT = 4'h0;
    localparam logic [3:0] MODE_DATA  = 4'h1;
endpackage

// File: rtl/sd_word_fifo.sv
module sd_word_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic             push_ok, pop_ok;

    assign push_ok = push && (level != LW'(DEPTH));
    assign pop_ok  = pop && (level != '0);
    assign head    = (level == '0) ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + LW'(1);
            else if (pop_ok && !push_ok) level <= level - LW'(1);
        end
    end
endmodule

// File: rtl/sd_byte_lane_ctl.sv
module sd_byte_lane_ctl
    import sd_pack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 19,
    parameter int BSZ_W  = 10,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              dir_read,
    input  logic              dir_write,
    input  logic              card_rdy,
    input  logic [7:0]        card_rx_byte,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              bus_push,
    input  logic              bus_pop,
    output logic              eng_push,
    output logic [DATA_W-1:0] eng_push_data,
    output logic              eng_pop,
    output logic              card_rx_take,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_byte,
    output logic              set_data,
    output logic              blk_edge,
    output logic              to_data_mode
);
    eng_state_t          state_q, state_d;
    logic [CNT_W-1:0]    rem_cnt;
    logic [BSZ_W-1:0]    blk_left;
    logic [DATA_W-1:0]   word_acc, merged;
    logic [LANE_W-1:0]   lane_idx;
    logic [LANE_W:0]     send_left;
    logic                last_byte, word_done, fifo_full;

    assign fifo_full = (fifo_level == LVL_W'(DEPTH));
    assign last_byte = (rem_cnt == CNT_W'(1));
    assign word_done = (lane_idx == LANE_W'(LANES - 1)) || last_byte;

    always_comb begin
        merged = word_acc;
        merged[{lane_idx, 3'b000} +: 8] = card_rx_byte;
    end

    // next state and outputs
    always_comb begin
        state_d       = state_q;
        card_rx_take  = 1'b0;
        eng_push      = 1'b0;
        eng_pop       = 1'b0;
        card_tx_valid = 1'b0;
        unique case (state_q)
            ENG_IDLE: begin
                if (rem_cnt != '0) begin
                    if (dir_read)       state_d = ENG_RD_GATHER;
                    else if (dir_write) state_d = ENG_WR_FETCH;
                end
            end
            ENG_RD_GATHER: begin
                card_rx_take = card_rdy && !fifo_full && !bus_push;
                eng_push     = card_rx_take && word_done;
                if (card_rx_take && last_byte) state_d = ENG_IDLE;
            end
            ENG_WR_FETCH: begin
                eng_pop = (fifo_level != '0) && !bus_pop;
                if (eng_pop) state_d = ENG_WR_SEND;
            end
            ENG_WR_SEND: begin
                card_tx_valid = 1'b1;
                if (last_byte)                           state_d = ENG_IDLE;
                else if (send_left == (LANE_W + 1)'(1))  state_d = ENG_WR_FETCH;
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    assign eng_push_data = merged;
    assign card_tx_byte  = word_acc[7:0];
    assign set_data      = eng_push || eng_pop || card_tx_valid;
    assign blk_edge      = card_tx_valid && (blk_left == BSZ_W'(1));
    assign to_data_mode  = (card_rx_take || card_tx_valid) && last_byte;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ENG_IDLE;
            rem_cnt   <= '0;
            blk_left  <= '0;
            word_acc  <= '0;
            lane_idx  <= '0;
            send_left <= '0;
        end else if (load) begin
            state_q  <= ENG_IDLE;
            rem_cnt  <= load_cnt;
            blk_left <= blk_size;
            word_acc <= '0;
            lane_idx <= '0;
        end else begin
            state_q <= state_d;
            if (card_rx_take) begin
                rem_cnt <= rem_cnt - CNT_W'(1);
                if (word_done) begin
                    word_acc <= '0;
                    lane_idx <= '0;
                end else begin
                    word_acc <= merged;
                    lane_idx <= lane_idx + LANE_W'(1);
                end
            end
            if (eng_pop) begin
                word_acc  <= fifo_head;
                send_left <= (LANE_W + 1)'(LANES);
            end
            if (card_tx_valid) begin
                word_acc  <= word_acc >> 8;
                send_left <= send_left - (LANE_W + 1)'(1);
                rem_cnt   <= rem_cnt - CNT_W'(1);
                blk_left  <= (blk_left == BSZ_W'(1)) ? blk_size : blk_left - BSZ_W'(1);
            end
        end
    end
endmodule

// File: rtl/sd_fifo_pack_engine.sv
module sd_fifo_pack_engine
    import sd_pack_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int BSZ_W  = 10,
    parameter int BCNT_W = 9,
    localparam int CNT_W = BSZ_W + BCNT_W,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              xfer_read,
    input  logic              xfer_write,
    input  logic              cfg_data_irq_en,
    input  logic              cfg_block_irq_en,
    input  logic [BSZ_W-1:0]  blk_size,
    input  logic              blk_cnt_wr,
    input  logic [BCNT_W-1:0] blk_cnt,
    input  logic              stat_clr_en,
    input  logic [STAT_W-1:0] stat_clr_mask,
    output logic [STAT_W-1:0] status,
    input  logic              card_rdy,
    input  logic [7:0]        card_rx_byte,
    output logic              card_rx_take,
    output logic              card_tx_valid,
    output logic [7:0]        card_tx_byte,
    output logic [3:0]        dbg_fsm,
    output logic [LVL_W-1:0]  dbg_level
);
    logic              eng_push, eng_pop, set_data, blk_edge, to_data_mode;
    logic [DATA_W-1:0] eng_push_data;
    logic [CNT_W-1:0]  load_cnt;
    logic [STAT_W-1:0] stat_set, stat_q;
    logic [3:0]        mode_q;

    assign load_cnt = CNT_W'(blk_cnt) * CNT_W'(blk_size);

    sd_word_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (host_wr_en || eng_push),
        .push_data (host_wr_en ? host_wr_data : eng_push_data),
        .pop       (host_rd_en || eng_pop),
        .head      (host_rd_data),
        .level     (dbg_level)
    );

    sd_byte_lane_ctl #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .BSZ_W(BSZ_W)
    ) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (blk_cnt_wr),
        .load_cnt      (load_cnt),
        .blk_size      (blk_size),
        .dir_read      (xfer_read),
        .dir_write     (xfer_write),
        .card_rdy      (card_rdy),
        .card_rx_byte  (card_rx_byte),
        .fifo_level    (dbg_level),
        .fifo_head     (host_rd_data),
        .bus_push      (host_wr_en),
        .bus_pop       (host_rd_en),
        .eng_push      (eng_push),
        .eng_push_data (eng_push_data),
        .eng_pop       (eng_pop),
        .card_rx_take  (card_rx_take),
        .card_tx_valid (card_tx_valid),
        .card_tx_byte  (card_tx_byte),
        .set_data      (set_data),
        .blk_edge      (blk_edge),
        .to_data_mode  (to_data_mode)
    );

    always_comb begin
        stat_set                = '0;
        stat_set[STAT_DATA]     = set_data;
        stat_set[STAT_DATA_IRQ] = set_data && cfg_data_irq_en;
        stat_set[STAT_BLOCK]    = blk_edge && cfg_block_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mode_q <= MODE_IDENT;
        end else begin
            stat_q <= (stat_q & ~(stat_clr_en ? stat_clr_mask : '0)) | stat_set;
            if (to_data_mode) mode_q <= MODE_DATA;
        end
    end

    assign status  = stat_q;
    assign dbg_fsm = mode_q;
endmodule

// File: rtl/sd_pack_checker.sv
module sd_pack_checker
    import sd_pack_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  dbg_level,
    input logic [DATA_W-1:0] host_rd_data,
    input logic              host_wr_en,
    input logic              card_rdy,
    input logic              card_rx_take,
    input logic              card_tx_valid,
    input logic [STAT_W-1:0] status,
    input logic [3:0]        dbg_fsm
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dbg_level) <= DEPTH); // R1
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(dbg_level) <= int'($past(dbg_level)) + 1) &&
        (int'(dbg_level) + 1 >= int'($past(dbg_level)))); // R1
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_level == '0) |-> (host_rd_data == '0)); // R2
    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_take |-> (card_rdy && int'(dbg_level) < DEPTH)); // R5
    AST_BUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_take |-> !host_wr_en); // R11
    AST_SINGLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_rx_take && card_tx_valid)); // R7
    AST_BLOCK_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STAT_BLOCK]) |-> $past(card_tx_valid)); // R9
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_fsm == MODE_DATA) |=> (dbg_fsm == MODE_DATA)); // R10
endmodule

bind sd_fifo_pack_engine sd_pack_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dbg_level     (dbg_level),
    .host_rd_data  (host_rd_data),
    .host_wr_en    (host_wr_en),
    .card_rdy      (card_rdy),
    .card_rx_take  (card_rx_take),
    .card_tx_valid (card_tx_valid),
    .status        (status),
    .dbg_fsm       (dbg_fsm)
);

// File: tb/sim_sd_fifo_pack_engine.sv
`timescale 1ns/1ps
module sim_sd_fifo_pack_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 0, host_rd_en = 0;
    logic [31:0] host_wr_data = 0, host_rd_data;
    logic        xfer_read = 0, xfer_write = 0;
    logic        cfg_data_irq_en = 0, cfg_block_irq_en = 0;
    logic [9:0]  blk_size = 0;
    logic        blk_cnt_wr = 0;
    logic [8:0]  blk_cnt = 0;
    logic        stat_clr_en = 0;
    logic [10:0] stat_clr_mask = 0, status;
    logic        card_rdy = 0, card_rx_take, card_tx_valid;
    logic [7:0]  card_rx_byte, card_tx_byte;
    logic [3:0]  dbg_fsm;
    logic [4:0]  dbg_level;

    int checks = 0, failures = 0;
    bit done = 0;
    int rx_idx = 0;
    int tx_cnt = 0;
    logic [7:0] tx_log [256];

    always #2.5 clk = ~clk;

    sd_fifo_pack_engine u0 (.*);

    function automatic logic [7:0] pat(int i);
        return 8'((i * 29 + 3) & 255);
    endfunction

    assign card_rx_byte = pat(rx_idx);

    always @(posedge clk) begin
        if (card_rx_take) rx_idx <= rx_idx + 1;
        if (card_tx_valid) begin
            tx_log[tx_cnt & 255] <= card_tx_byte;
            tx_cnt <= tx_cnt + 1;
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(logic [31:0] w);
        host_wr_en = 1; host_wr_data = w;
        cyc(1);
        host_wr_en = 0;
    endtask

    task automatic pop_word(output logic [31:0] w);
        w = host_rd_data;
        host_rd_en = 1;
        cyc(1);
        host_rd_en = 0;
    endtask

    task automatic load(int n, int sz);
        blk_cnt = 9'(n); blk_size = 10'(sz); blk_cnt_wr = 1;
        cyc(1);
        blk_cnt_wr = 0;
    endtask

    task automatic clear_status();
        stat_clr_en = 1; stat_clr_mask = '1;
        cyc(1);
        stat_clr_en = 0; stat_clr_mask = '0;
    endtask

    function automatic logic [31:0] exp_rd(int base, int k, int nbytes);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++)
            if (k * 4 + j < nbytes) w[j*8 +: 8] = pat(base + k * 4 + j);
        return w;
    endfunction

    function automatic logic [31:0] wpat(int row, int k);
        return {8'(row), 8'(k), 8'hC3, 8'(k * 5 + row)};
    endfunction

    // vector: [31] write, [30] data irq en, [29] block irq en, [24:16] blocks, [9:0] block size
    localparam logic [31:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 4'b0, 9'd1, 6'd0, 10'd4},
        {1'b0, 1'b0, 1'b0, 4'b0, 9'd1, 6'd0, 10'd6},
        {1'b0, 1'b1, 1'b1, 4'b0, 9'd2, 6'd0, 10'd3},
        {1'b1, 1'b1, 1'b1, 4'b0, 9'd2, 6'd0, 10'd4},
        {1'b1, 1'b0, 1'b1, 4'b0, 9'd1, 6'd0, 10'd5},
        {1'b1, 1'b0, 1'b0, 4'b0, 9'd3, 6'd0, 10'd2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1..: act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        cyc(4);
        rst_n = 1;
        cyc(1);
        // reset state
        chk(dbg_level == 0, "R1 reset level", 32'(dbg_level), 0);
        chk(status == 0, "R8 reset status", 32'(status), 0);
        chk(dbg_fsm == 4'h0, "R10 reset mode", 32'(dbg_fsm), 0);
        chk(host_rd_data == 0, "R2 empty reads zero", host_rd_data, 0);

        // overflow and underflow with engine idle
        for (int k = 0; k < 17; k++) push_word(32'h5000_0000 + 32'(k));
        chk(dbg_level == 16, "R1 full level", 32'(dbg_level), 16);
        for (int k = 0; k < 16; k++) begin
            pop_word(w);
            chk(w == 32'h5000_0000 + 32'(k), "R2 order after overflow", w, 32'h5000_0000 + 32'(k));
        end
        chk(host_rd_data == 0, "R2 extra word dropped", host_rd_data, 0);
        pop_word(w);
        chk(w == 0 && dbg_level == 0, "R2 pop on empty", w, 0);

        // table of transfers
        for (int r = 0; r < 6; r++) begin
            automatic logic [31:0] v = VEC[r];
            automatic int n = int'(v[24:16]) * int'(v[9:0]);
            automatic int words = (n + 3) / 4;
            automatic int base;
            cfg_data_irq_en = v[30]; cfg_block_irq_en = v[29];
            clear_status();
            if (!v[31]) begin
                card_rdy = 1; xfer_read = 1;
                base = rx_idx;
                load(int'(v[24:16]), int'(v[9:0]));
                cyc(n + 8);
                chk(rx_idx - base == n, "R3 read byte count", 32'(rx_idx - base), 32'(n));
                chk(dbg_level == 5'(words), "R4 read words queued", 32'(dbg_level), 32'(words));
                chk(status[0] == 1 && status[8] == v[30], "R8 read flags", 32'(status), 32'(v[30]));
                chk(status[10] == 0, "R9 no block flag on read", 32'(status[10]), 0);
                chk(dbg_fsm == 4'h1, "R10 data mode", 32'(dbg_fsm), 1);
                for (int k = 0; k < words; k++) begin
                    pop_word(w);
                    chk(w == exp_rd(base, k, n), "R6 R4 packed word", w, exp_rd(base, k, n));
                end
                xfer_read = 0; card_rdy = 0;
            end else begin
                for (int k = 0; k < words; k++) push_word(wpat(r, k));
                base = tx_cnt;
                xfer_write = 1;
                load(int'(v[24:16]), int'(v[9:0]));
                cyc(5 * words + 10);
                chk(tx_cnt - base == n, "R7 bytes sent", 32'(tx_cnt - base), 32'(n));
                for (int i = 0; i < n; i++) begin
                    automatic logic [31:0] ew = wpat(r, i / 4);
                    automatic logic [7:0] eb = ew[(i % 4) * 8 +: 8];
                    chk(tx_log[(base + i) & 255] == eb, "R7 byte order", 32'(tx_log[(base + i) & 255]), 32'(eb));
                end
                chk(dbg_level == 0, "R7 fifo drained", 32'(dbg_level), 0);
                chk(status[0] == 1 && status[8] == v[30], "R8 write flags", 32'(status), 32'(v[30]));
                chk(status[10] == v[29], "R9 block flag", 32'(status[10]), 32'(v[29]));
                xfer_write = 0;
            end
        end

        // block flag timing: two blocks of four bytes
        begin
            automatic int base;
            automatic bit bad = 0;
            cfg_block_irq_en = 1;
            push_word(32'h0403_0201); push_word(32'h0807_0605);
            clear_status();
            xfer_write = 1; base = tx_cnt;
            load(2, 4);
            for (int i = 0; i < 20; i++) begin
                if (status[10] != ((tx_cnt - base) >= 4)) bad = 1;
                cyc(1);
            end
            chk(!bad, "R9 block flag timing", 32'(bad), 0);
            xfer_write = 0;
        end

        // R12: clear only bit 0
        stat_clr_en = 1; stat_clr_mask = 11'h001;
        cyc(1);
        stat_clr_en = 0; stat_clr_mask = 0;
        chk(status == 11'h400, "R12 partial clear", 32'(status), 32'h400);

        // card not ready stalls the read
        begin
            automatic int base = rx_idx;
            xfer_read = 1; card_rdy = 0;
            load(1, 8);
            cyc(10);
            chk(dbg_level == 0 && rx_idx == base, "R4 waits for card ready", 32'(rx_idx - base), 0);
            card_rdy = 1;
            cyc(12);
            chk(dbg_level == 2, "R4 resumes when ready", 32'(dbg_level), 2);
            for (int k = 0; k < 2; k++) begin
                pop_word(w);
                chk(w == exp_rd(base, k, 8), "R4 word after stall", w, exp_rd(base, k, 8));
            end
        end

        // full FIFO stalls the read
        begin
            automatic int base = rx_idx;
            load(1, 80);
            cyc(100);
            chk(dbg_level == 16, "R5 stalled at full", 32'(dbg_level), 16);
            chk(rx_idx - base == 64, "R5 no bytes while full", 32'(rx_idx - base), 64);
            for (int k = 0; k < 20; k++) begin
                pop_word(w);
                chk(w == exp_rd(base, k, 80), "R5 words after stall", w, exp_rd(base, k, 80));
                cyc(6);
            end
        end

        // reload discards a partial word
        begin
            automatic int base;
            card_rdy = 0;
            load(1, 8);
            cyc(3);
            card_rdy = 1;
            cyc(2);
            card_rdy = 0;
            base = rx_idx;
            load(1, 4);
            card_rdy = 1;
            cyc(10);
            chk(dbg_level == 1, "R3 reload level", 32'(dbg_level), 1);
            pop_word(w);
            chk(w == exp_rd(base, 0, 4), "R3 reload fresh word", w, exp_rd(base, 0, 4));
        end

        // host push has priority over engine byte take
        begin
            load(1, 8);
            cyc(2);
            #1;
            chk(card_rx_take == 1, "R11 engine active", 32'(card_rx_take), 1);
            host_wr_en = 1; host_wr_data = 32'hCAFE_0001;
            #1;
            chk(card_rx_take == 0, "R11 host push wins", 32'(card_rx_take), 0);
            cyc(1);
            host_wr_en = 0;
            cyc(12);
            chk(dbg_level == 3, "R11 both words kept", 32'(dbg_level), 3);
            for (int k = 0; k < 3; k++) pop_word(w);
            xfer_read = 0; card_rdy = 0;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule